// File: doc/BRIEF.md
# Transfer Queue Tracker with Watchdog

This block keeps the bookkeeping for one DMA channel that runs transfers one at a time from a ring of slots. A client submits a transfer. The tracker gives it the next slot and a 32-bit sequence handle. Whenever the channel is idle and work is waiting, the tracker launches the oldest waiting transfer. It then watches the channel's status inputs to see whether the transfer finished normally or ended after an abort. A completed slot is handed back to the free pool one cycle later, by a service pointer that follows the completion pointer.

A cycle-count watchdog runs while a transfer is in flight. When it runs out, the tracker asks the channel to abort and starts the count again. An aborted transfer raises no done status, so the tracker treats the channel's enable dropping during an abort as the end of that transfer. A query port tells any client whether a given handle is still in flight. The comparison stays correct when the handle counters wrap, as long as the handles in question lie within 2^23 of the counters.

Top module: `xq_tracker`

## Requirements
- R1: An accepted submission (`sub_valid` high while `sub_accept` is high at a clock edge) is given slot `sub_slot`, which equals the head pointer. It is also given handle `sub_handle`, which is the last issued handle plus one; the first handle after reset is 1. The head pointer advances modulo SLOTS, so the (SLOTS+1)-th submission reuses slot 0.
- R2: `free_count` is SLOTS-1 after reset and drops by one for each accepted submission. `sub_accept` is low while `free_count` is 0. A submission refused this way consumes neither a handle nor a slot.
- R3: While no transfer is in flight and at least one is waiting, `ch_fire` is high for exactly one cycle, and `ch_slot` gives the slot being launched. Slots launch in submission order.
- R4: While a transfer is in flight and `ch_done` is high, `cmp_valid` and `ch_clr_done` are high in that same cycle, with `cmp_aborted` low and `cmp_slot` giving the completed slot. The done handle then advances by one and the channel returns to idle.
- R5: If a transfer stays in flight with `ch_done` low and `ch_en` high, `ch_abort` goes high for one cycle exactly TIMEOUT cycles after the `ch_fire` cycle. It goes high again every TIMEOUT cycles after that.
- R6: Once an abort has been issued, `ch_en` low completes the transfer: `cmp_valid` is high with `cmp_aborted` high, and `ch_done` is not needed. While `ch_en` stays high, no completion is reported.
- R7: `ch_off` is high exactly when no transfer is in flight and none is waiting.
- R8: `q_active` is high exactly when, in modulo 2^32 arithmetic, (done handle − `q_handle`) > 2^23 and (last issued handle − `q_handle`) ≤ 2^23.
- R9: In the cycle after each completion, `rel_valid` is high with `rel_slot` equal to the completed slot. `free_count` is one higher after the following edge.
- R10: `ch_done` while nothing is in flight is ignored: no completion is reported and `free_count`, `ch_off` are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_valid | input | 1 | Submission request |
| sub_accept | output | 1 | Submission can be taken this cycle |
| sub_handle | output | HW | Handle given to a submission taken this cycle |
| sub_slot | output | SW | Slot given to a submission taken this cycle |
| ch_done | input | 1 | Channel done status |
| ch_en | input | 1 | Channel enable status |
| ch_fire | output | 1 | Launch the transfer held in `ch_slot` |
| ch_slot | output | SW | Current slot (launched or in flight) |
| ch_abort | output | 1 | Abort request to the channel |
| ch_clr_done | output | 1 | Clear the channel done status |
| ch_off | output | 1 | Channel may be switched off |
| cmp_valid | output | 1 | A transfer has ended this cycle |
| cmp_aborted | output | 1 | The ending transfer had been aborted |
| cmp_slot | output | SW | Slot of the ending transfer |
| rel_valid | output | 1 | A slot goes back to the free pool |
| rel_slot | output | SW | Slot being freed |
| free_count | output | CW | Number of free slots |
| q_handle | input | HW | Handle to query |
| q_active | output | 1 | Queried handle is still in flight |

## Verification
The bench fills the ring until submissions are refused. A design that miscounted free slots would accept a fourth transfer, or would use up a handle on a refused request, and later handles would then come out shifted. The bench lets the head pointer wrap back to slot 0 and checks that slots launch and retire in submission order. It holds a transfer in flight past two watchdog periods to catch an off-by-one in the abort cycle, and then drops the enable to catch a design that waits for a done status after an abort. At each stage it sweeps query handles across both 2^23 window edges around the done and issued counters; a signed or off-by-one comparison reports the wrong state there.

// File: rtl/xq_pkg.sv
package xq_pkg;
   typedef enum logic [1:0] {
      CH_IDLE     = 2'd0,
      CH_RUN      = 2'd1,
      CH_ABORTING = 2'd2
   } ch_state_e;
endpackage

// File: rtl/xq_ptr.sv
module xq_ptr #(
   parameter int DEPTH = 8,
   parameter int PW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [PW-1:0] ptr
);
   localparam bit IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic [PW-1:0] nxt;

   generate
      if (IS_POW2) begin : g_pow2
         assign nxt = ptr + 1'b1;
      end else begin : g_cmp
         assign nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (adv)
         ptr <= nxt;
   end
endmodule

// File: rtl/xq_wdog.sv
module xq_wdog #(
   parameter int TIMEOUT = 1000,
   parameter int TW      = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload,
   input  logic run,
   output logic expired
);
   localparam logic [TW-1:0] RELOAD_V = TW'(TIMEOUT - 1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (reload)
         cnt <= RELOAD_V;
      else if (run && cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/xq_hcmp.sv
module xq_hcmp #(
   parameter int HW    = 32,
   parameter int WLOG2 = 23
) (
   input  logic [HW-1:0] done_h,
   input  logic [HW-1:0] last_h,
   input  logic [HW-1:0] q_h,
   output logic          in_flight
);
   localparam logic [HW-1:0] WIN = HW'(1) << WLOG2;

   logic [HW-1:0] d_gap;
   logic [HW-1:0] l_gap;

   assign d_gap     = done_h - q_h;
   assign l_gap     = last_h - q_h;
   assign in_flight = (d_gap > WIN) && (l_gap <= WIN);
endmodule

// File: rtl/xq_tracker.sv
module xq_tracker #(
   parameter int SLOTS   = 8,
   parameter int TIMEOUT = 1000000,
   parameter int HW      = 32,
   parameter int WLOG2   = 23,
   parameter int SW      = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   parameter int CW      = $clog2(SLOTS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sub_valid,
   output logic          sub_accept,
   output logic [HW-1:0] sub_handle,
   output logic [SW-1:0] sub_slot,
   input  logic          ch_done,
   input  logic          ch_en,
   output logic          ch_fire,
   output logic [SW-1:0] ch_slot,
   output logic          ch_abort,
   output logic          ch_clr_done,
   output logic          ch_off,
   output logic          cmp_valid,
   output logic          cmp_aborted,
   output logic [SW-1:0] cmp_slot,
   output logic          rel_valid,
   output logic [SW-1:0] rel_slot,
   output logic [CW-1:0] free_count,
   input  logic [HW-1:0] q_handle,
   output logic          q_active
);
   import xq_pkg::*;

   localparam int TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 2;
   localparam logic [CW-1:0] FREE_INIT = CW'(SLOTS - 1);

   generate
      if (SLOTS < 2) begin : g_bad_slots
         $error("xq_tracker: SLOTS must be at least 2");
      end
      if (TIMEOUT < 2) begin : g_bad_timeout
         $error("xq_tracker: TIMEOUT must be at least 2");
      end
      if (WLOG2 >= HW - 1) begin : g_bad_window
         $error("xq_tracker: WLOG2 must be below HW-1");
      end
      if (SW < $clog2(SLOTS)) begin : g_bad_sw
         $error("xq_tracker: SW too narrow for SLOTS");
      end
   endgenerate

   ch_state_e     st_q, st_d;
   logic [CW-1:0] free_q, outst_q;
   logic [HW-1:0] last_h_q, done_h_q;
   logic [SW-1:0] head_p, cur_p, svc_p;

   logic active, aborting, take, fin, fire, abort_now, release_now, expired;

   assign active      = (st_q != CH_IDLE);
   assign aborting    = (st_q == CH_ABORTING);
   assign take        = sub_valid && (free_q != '0);
   assign fin         = (active && ch_done) || (aborting && !ch_en);
   assign fire        = !active && (outst_q != '0);
   assign abort_now   = active && !fin && expired;
   assign release_now = (svc_p != cur_p);

   xq_ptr #(.DEPTH(SLOTS), .PW(SW)) u_head (
      .clk(clk), .rst_n(rst_n), .adv(take), .ptr(head_p));
   xq_ptr #(.DEPTH(SLOTS), .PW(SW)) u_cur (
      .clk(clk), .rst_n(rst_n), .adv(fin), .ptr(cur_p));
   xq_ptr #(.DEPTH(SLOTS), .PW(SW)) u_svc (
      .clk(clk), .rst_n(rst_n), .adv(release_now), .ptr(svc_p));

   xq_wdog #(.TIMEOUT(TIMEOUT), .TW(TW)) u_wdog (
      .clk(clk), .rst_n(rst_n),
      .reload(fire || abort_now),
      .run(active),
      .expired(expired));

   xq_hcmp #(.HW(HW), .WLOG2(WLOG2)) u_hcmp (
      .done_h(done_h_q), .last_h(last_h_q), .q_h(q_handle),
      .in_flight(q_active));

   always_comb begin
      st_d = st_q;
      if (fin)
         st_d = CH_IDLE;
      else if (abort_now)
         st_d = CH_ABORTING;
      else if (fire)
         st_d = CH_RUN;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= CH_IDLE;
         free_q   <= FREE_INIT;
         outst_q  <= '0;
         last_h_q <= '0;
         done_h_q <= '0;
      end else begin
         st_q <= st_d;
         case ({take, release_now})
            2'b10:   free_q <= free_q - 1'b1;
            2'b01:   free_q <= free_q + 1'b1;
            default: free_q <= free_q;
         endcase
         case ({take, fire})
            2'b10:   outst_q <= outst_q + 1'b1;
            2'b01:   outst_q <= outst_q - 1'b1;
            default: outst_q <= outst_q;
         endcase
         if (take)
            last_h_q <= last_h_q + 1'b1;
         if (fin)
            done_h_q <= done_h_q + 1'b1;
      end
   end

   assign sub_accept  = (free_q != '0);
   assign sub_handle  = last_h_q + 1'b1;
   assign sub_slot    = head_p;
   assign ch_fire     = fire;
   assign ch_slot     = cur_p;
   assign ch_abort    = abort_now;
   assign ch_clr_done = fin;
   assign ch_off      = !active && (outst_q == '0);
   assign cmp_valid   = fin;
   assign cmp_aborted = aborting;
   assign cmp_slot    = cur_p;
   assign rel_valid   = release_now;
   assign rel_slot    = svc_p;
   assign free_count  = free_q;
endmodule

// File: rtl/xq_tracker_chk.sv
module xq_tracker_chk #(
   parameter int SLOTS   = 8,
   parameter int TIMEOUT = 1000000,
   parameter int HW      = 32,
   parameter int WLOG2   = 23,
   parameter int SW      = 3,
   parameter int CW      = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sub_valid,
   input logic          sub_accept,
   input logic [HW-1:0] sub_handle,
   input logic          ch_fire,
   input logic          ch_abort,
   input logic          cmp_valid,
   input logic          rel_valid,
   input logic [CW-1:0] free_count
);
   localparam logic [CW-1:0] FREE_MAX = CW'(SLOTS - 1);

   assert_free_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      free_count <= FREE_MAX);

   assert_take_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_valid && sub_accept && !rel_valid) |=> (free_count == $past(free_count) - 1'b1));

   assert_handle_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_valid && sub_accept) |=> (sub_handle == $past(sub_handle) + 1'b1));

   assert_refuse_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(sub_valid && sub_accept)) |=> $stable(sub_handle));

   assert_fire_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ch_fire |=> !ch_fire);

   assert_abort_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ch_abort |=> !ch_abort);

   assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ch_fire, ch_abort, cmp_valid}));

   assert_cmp_rel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid |=> rel_valid);
endmodule

bind xq_tracker xq_tracker_chk #(
   .SLOTS(SLOTS), .TIMEOUT(TIMEOUT), .HW(HW), .WLOG2(WLOG2), .SW(SW), .CW(CW)
) u_chk (.*);

// File: tb/sim_xq_tracker.sv
module sim_xq_tracker;
   localparam int SLOTS = 4;
   localparam int TO    = 6;
   localparam int HW    = 32;
   localparam int SW    = 2;
   localparam int CW    = 3;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n, sub_valid, ch_done, ch_en;
   logic          sub_accept, ch_fire, ch_abort, ch_clr_done, ch_off;
   logic          cmp_valid, cmp_aborted, rel_valid, q_active;
   logic [HW-1:0] sub_handle, q_handle;
   logic [SW-1:0] sub_slot, ch_slot, cmp_slot, rel_slot;
   logic [CW-1:0] free_count;

   xq_tracker #(.SLOTS(SLOTS), .TIMEOUT(TO), .HW(HW), .WLOG2(23), .SW(SW), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_accept(sub_accept),
      .sub_handle(sub_handle), .sub_slot(sub_slot), .ch_done(ch_done), .ch_en(ch_en),
      .ch_fire(ch_fire), .ch_slot(ch_slot), .ch_abort(ch_abort),
      .ch_clr_done(ch_clr_done), .ch_off(ch_off), .cmp_valid(cmp_valid),
      .cmp_aborted(cmp_aborted), .cmp_slot(cmp_slot), .rel_valid(rel_valid),
      .rel_slot(rel_slot), .free_count(free_count), .q_handle(q_handle),
      .q_active(q_active));

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;
   logic [31:0] m_done = 0;
   logic [31:0] m_last = 0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic nxt();
      @(negedge clk);
      #5;
   endtask

   function automatic bit exp_q(input logic [31:0] d, input logic [31:0] c, input logic [31:0] q);
      logic [31:0] dg, cg;
      dg = d - q;
      cg = c - q;
      return (dg > 32'h0080_0000) && (cg <= 32'h0080_0000);
   endfunction

   task automatic qsweep();
      logic [31:0] pts [14];
      pts[0]  = m_last;                  pts[1]  = m_last + 1;
      pts[2]  = m_last - 1;              pts[3]  = m_done;
      pts[4]  = m_done + 1;              pts[5]  = m_done - 1;
      pts[6]  = m_last - 32'h0080_0000;  pts[7]  = m_last - 32'h0080_0001;
      pts[8]  = m_last - 32'h007F_FFFF;  pts[9]  = m_done - 32'h0080_0001;
      pts[10] = m_done - 32'h0080_0000;  pts[11] = m_done + 32'h0080_0000;
      pts[12] = 32'h0;                   pts[13] = 32'hFFFF_FFFF;
      for (int i = 0; i < 14; i++) begin
         q_handle = pts[i];
         #1;
         chk("R8", $sformatf("q_active for handle %h", pts[i]), q_active,
             exp_q(m_done, m_last, pts[i]));
      end
      q_handle = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 0; sub_valid = 0; ch_done = 0; ch_en = 1; q_handle = '0;
      nxt(); nxt(); nxt();
      rst_n = 1;
      nxt();
      #1;
      // reset state
      chk("R2", "free_count after reset", free_count, SLOTS - 1);
      chk("R2", "sub_accept after reset", sub_accept, 1);
      chk("R7", "ch_off after reset", ch_off, 1);
      chk("R3", "ch_fire after reset", ch_fire, 0);
      chk("R1", "first handle", sub_handle, 1);
      // R10: done while idle is ignored
      ch_done = 1;
      #1;
      chk("R10", "cmp_valid on idle done", cmp_valid, 0);
      chk("R10", "ch_clr_done on idle done", ch_clr_done, 0);
      nxt();
      ch_done = 0;
      #1;
      chk("R10", "free_count after idle done", free_count, SLOTS - 1);
      chk("R10", "ch_off after idle done", ch_off, 1);
      qsweep();

      // single transfer
      sub_valid = 1;
      #1;
      chk("R1", "handle of first submit", sub_handle, 1);
      chk("R1", "slot of first submit", sub_slot, 0);
      nxt();
      sub_valid = 0; m_last = 1;
      #1;
      chk("R3", "fire after submit", ch_fire, 1);
      chk("R3", "fire slot", ch_slot, 0);
      chk("R7", "ch_off with work waiting", ch_off, 0);
      chk("R2", "free after one submit", free_count, SLOTS - 2);
      nxt();
      #1;
      chk("R3", "fire is one cycle", ch_fire, 0);
      chk("R7", "ch_off while in flight", ch_off, 0);
      qsweep();
      ch_done = 1;
      #1;
      chk("R4", "cmp_valid on done", cmp_valid, 1);
      chk("R4", "clr_done on done", ch_clr_done, 1);
      chk("R4", "cmp_aborted on done", cmp_aborted, 0);
      chk("R4", "cmp_slot", cmp_slot, 0);
      nxt();
      ch_done = 0; m_done = 1;
      #1;
      chk("R9", "rel_valid after completion", rel_valid, 1);
      chk("R9", "rel_slot", rel_slot, 0);
      chk("R7", "ch_off after completion", ch_off, 1);
      qsweep();
      nxt();
      #1;
      chk("R9", "free after release", free_count, SLOTS - 1);
      chk("R9", "single release", rel_valid, 0);

      // fill the ring
      sub_valid = 1;
      #1;
      chk("R1", "handle 2", sub_handle, 2);
      chk("R1", "slot 1", sub_slot, 1);
      nxt();
      #1;
      chk("R1", "handle 3", sub_handle, 3);
      chk("R1", "slot 2", sub_slot, 2);
      chk("R3", "fire slot 1", ch_fire, 1);
      chk("R3", "fire slot 1 index", ch_slot, 1);
      nxt();
      #1;
      chk("R1", "handle 4", sub_handle, 4);
      chk("R1", "slot 3", sub_slot, 3);
      chk("R2", "free with two taken", free_count, 1);
      nxt();
      #1;
      chk("R2", "accept low when full", sub_accept, 0);
      chk("R2", "free zero", free_count, 0);
      nxt();
      sub_valid = 0; m_last = 4;
      #1;
      chk("R2", "refused submit keeps handle", sub_handle, 5);
      chk("R2", "free still zero", free_count, 0);
      qsweep();
      for (int s = 1; s <= 3; s++) begin
         nxt();
         ch_done = 1;
         #1;
         chk("R4", "cmp_valid in fill drain", cmp_valid, 1);
         chk("R4", "cmp_slot in order", cmp_slot, s);
         chk("R4", "not aborted", cmp_aborted, 0);
         nxt();
         ch_done = 0; m_done = m_done + 1;
         #1;
         chk("R9", "release in drain", rel_valid, 1);
         chk("R9", "release slot in drain", rel_slot, s);
         if (s < 3) begin
            chk("R3", "next fire", ch_fire, 1);
            chk("R3", "next fire slot order", ch_slot, s + 1);
         end else begin
            chk("R7", "off after drain", ch_off, 1);
            chk("R3", "no fire when empty", ch_fire, 0);
         end
         if (s == 2) qsweep();
      end
      nxt();
      #1;
      chk("R9", "free restored", free_count, SLOTS - 1);

      // head wrap and watchdog
      sub_valid = 1;
      #1;
      chk("R1", "head wraps to slot 0", sub_slot, 0);
      chk("R1", "handle 5", sub_handle, 5);
      nxt();
      sub_valid = 0; m_last = 5;
      #1;
      chk("R3", "fire wrapped slot", ch_fire, 1);
      chk("R3", "wrapped fire slot", ch_slot, 0);
      for (int i = 1; i <= 2 * TO; i++) begin
         nxt();
         #1;
         chk("R5", $sformatf("ch_abort cycle %0d", i), ch_abort, (i == TO || i == 2 * TO));
         chk("R6", $sformatf("no completion with enable high, cycle %0d", i), cmp_valid, 0);
      end
      nxt();
      ch_en = 0;
      #1;
      chk("R6", "completion on enable drop", cmp_valid, 1);
      chk("R6", "aborted flag", cmp_aborted, 1);
      chk("R6", "aborted slot", cmp_slot, 0);
      nxt();
      ch_en = 1; m_done = 5;
      #1;
      chk("R9", "release after abort", rel_valid, 1);
      chk("R7", "off after abort", ch_off, 1);
      qsweep();

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule